// File: doc/BRIEF.md
# Windowed Bus-to-Memory Address Translator

This block turns an address seen on the expansion bus into a 34-bit address in system memory. Four programmable windows are available. Each window has three 64-bit registers: a base, a size mask and a target base. Software programs them through a small register port that accepts only full 64-bit accesses. A window claims a bus address when the address agrees with the window base on the bits that the size mask leaves open within bits 30 to 20. The window must also be switched on.

A claiming window works in one of two ways. It can map the address straight onto its target base. It can also treat its target base as the origin of a page table: the block then fetches one 64-bit entry from memory, through a request/response handshake, and builds the address from that entry. Translation requests come in on a valid/ready handshake. Each result is presented for one cycle with a hit flag, and a miss gives address zero.

Top module: `dma_window_xlate`

## Requirements
- R1: After reset all twelve window registers read back as zero, and a translation reports hit=0 with address 0.
- R2: A register access with size 8 addresses register index = byte offset >> 6. Indices 0..3 are window bases 0..3, indices 4..7 are size masks 0..3, and indices 8..11 are target bases 0..3. A write stores the data. A read returns the stored value. reg_ack pulses in the cycle after the request, with reg_err=0.
- R3: An access whose reg_size is not 8, or whose index is 12 or above, gives reg_ack with reg_err=1 and read data 0, and it changes no register.
- R4: Window i matches bus address A when (A xor base_i) is zero on the bits of (~mask_i & 0x7FF00000).
- R5: Base bit 0 switches a window on. A matching window whose bit 0 is 0 is passed over, and the search goes on to the next window.
- R6: The lowest-numbered window that both matches and is switched on supplies the result.
- R7: When no window qualifies, the result has res_hit=0 and res_addr=0, and no memory read is issued.
- R8: A qualifying window with base bit 1 = 0 maps directly. With P = (mask & 0x7FF00000) | 0xFFFFF, the result is (A & P) | (target & ~P).
- R9: A qualifying window with base bit 1 = 1 issues exactly one memory read. With M = mask & 0x7FF00000, the read address is (target & ~((M >> 10) | 0x3FF)) | ((A & (M | 0xFE000)) >> 10). mem_req_valid and the address stay steady until mem_req_ready.
- R10: In that page-table mode the result is ((entry & ~1) << 12) | (A & 0x1FFF), where entry is the returned 64-bit data.
- R11: Every result is cut to its low 34 bits, so target or entry bits that land above bit 33 never appear.
- R12: req_ready is 0 from the cycle after a request is accepted until the cycle after res_valid. res_valid lasts exactly one cycle.
- R13: A register write made while a translation is in flight does not change that translation's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | OFS_W | Byte offset from the block base |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data |
| reg_ack | output | 1 | Access completed (one cycle after request) |
| reg_err | output | 1 | Access rejected |
| reg_rdata | output | 64 | Read data, valid with reg_ack |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a translation |
| req_addr | input | BUS_W | Bus address to translate |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | A window claimed the address |
| res_addr | output | DMA_W | Translated address |
| mem_req_valid | output | 1 | Page-table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry data |

## Verification
The bench sets up overlapping windows in which a switched-off window sits below a switched-on one that also matches. A design that ignored the enable bit, or that chose the highest match, would return the wrong window's mapping there. In page-table mode the bench compares the entry read address on its own, and it derives the returned entry from that address. A wrong slice of the mask or the target base therefore shows up twice: as a bad request address and as a bad result.

Target bases carry bits above 33, so a design that did not cut the result to 34 bits, or that let target bits leak under the pass-through mask, would produce extra high bits. A register write made in the middle of a slow memory fetch catches a design that reads live registers instead of its captured copy. Narrow accesses and accesses past index 11 catch a design that stores data or leaves reg_err low when it should reject the access.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
   // field geometry shared by compare and address formation
   localparam int REG_W      = 64;
   localparam int WIN_LO     = 20;
   localparam int WIN_HI     = 30;
   localparam int PTE_IDX_LO = 13;
   localparam int PTE_IDX_HI = 19;
   localparam int PTE_SHIFT  = 10;
   localparam int PAGE_SHIFT = 12;
   localparam int PAGE_OFS_W = 13;
   localparam int REG_GROUPS = 3;
   localparam int ACC_BYTES  = REG_W / 8;

   localparam logic [REG_W-1:0] WIN_FIELD =
      ((64'd1 << (WIN_HI - WIN_LO + 1)) - 64'd1) << WIN_LO;
   localparam logic [REG_W-1:0] LOW_PASS  = (64'd1 << WIN_LO) - 64'd1;
   localparam logic [REG_W-1:0] PTE_IDX_FIELD =
      ((64'd1 << (PTE_IDX_HI - PTE_IDX_LO + 1)) - 64'd1) << PTE_IDX_LO;
   localparam logic [REG_W-1:0] PTE_ALIGN = (64'd1 << PTE_SHIFT) - 64'd1;
   localparam logic [REG_W-1:0] PAGE_OFS  = (64'd1 << PAGE_OFS_W) - 64'd1;

   typedef enum logic [2:0] {
      XS_IDLE,
      XS_CMP,
      XS_FREQ,
      XS_WAIT,
      XS_DONE
   } xlate_state_e;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
   import xlate_pkg::*;
#(
   parameter int NWIN  = 4,
   parameter int OFS_W = 10
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_valid,
   input  logic                        reg_write,
   input  logic [OFS_W-1:0]            reg_addr,
   input  logic [3:0]                  reg_size,
   input  logic [REG_W-1:0]            reg_wdata,
   output logic                        reg_ack,
   output logic                        reg_err,
   output logic [REG_W-1:0]            reg_rdata,
   output logic [NWIN-1:0][REG_W-1:0]  wbase,
   output logic [NWIN-1:0][REG_W-1:0]  wmask,
   output logic [NWIN-1:0][REG_W-1:0]  tbase
);
   localparam int NREGS = REG_GROUPS * NWIN;

   if (NREGS * 64 > (1 << OFS_W)) begin : g_ofs_check
      $error("OFS_W too narrow for the register set");
   end

   logic [31:0]      idx_u;
   logic             size_ok;
   logic             idx_ok;
   logic             acc_ok;
   logic [REG_W-1:0] rd_mux;

   assign idx_u   = 32'(reg_addr) >> 6;
   assign size_ok = (reg_size == 4'(ACC_BYTES));
   assign idx_ok  = (idx_u < 32'(NREGS));
   assign acc_ok  = reg_valid && size_ok && idx_ok;

   for (genvar i = 0; i < NWIN; i++) begin : g_win_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wbase[i] <= '0;
            wmask[i] <= '0;
            tbase[i] <= '0;
         end else if (acc_ok && reg_write) begin
            if (idx_u == 32'(i))
               wbase[i] <= reg_wdata;
            if (idx_u == 32'(NWIN + i))
               wmask[i] <= reg_wdata;
            if (idx_u == 32'(2 * NWIN + i))
               tbase[i] <= reg_wdata;
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NWIN; i++) begin
         if (idx_u == 32'(i))            rd_mux = wbase[i];
         if (idx_u == 32'(NWIN + i))     rd_mux = wmask[i];
         if (idx_u == 32'(2 * NWIN + i)) rd_mux = tbase[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_ack   <= 1'b0;
         reg_err   <= 1'b0;
         reg_rdata <= '0;
      end else begin
         reg_ack   <= reg_valid;
         reg_err   <= reg_valid && !(size_ok && idx_ok);
         reg_rdata <= (acc_ok && !reg_write) ? rd_mux : '0;
      end
   end

   assert_reject_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid && !size_ok |=> reg_ack && reg_err);

   assert_reject_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid && reg_write && !(size_ok && idx_ok)
      |=> $stable(wbase) && $stable(wmask) && $stable(tbase));

   assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid |=> reg_ack);
endmodule

// File: rtl/xlate_window.sv
module xlate_window
   import xlate_pkg::*;
#(
   parameter int BUS_W = 32
) (
   input  logic [BUS_W-1:0] bus_addr,
   input  logic [REG_W-1:0] wbase,
   input  logic [REG_W-1:0] wmask,
   output logic             claim
);
   logic [REG_W-1:0] bus64;
   logic [REG_W-1:0] cmp_bits;
   logic             match;

   assign bus64    = REG_W'(bus_addr);
   assign cmp_bits = ~wmask & WIN_FIELD;
   assign match    = ((bus64 ^ wbase) & cmp_bits) == '0;
   assign claim    = match && wbase[0];
endmodule

// File: rtl/xlate_form.sv
module xlate_form
   import xlate_pkg::*;
#(
   parameter int DMA_W = 34
) (
   input  logic [REG_W-1:0] snap_bus,
   input  logic [REG_W-1:0] snap_mask,
   input  logic [REG_W-1:0] snap_tba,
   input  logic [REG_W-1:0] entry,
   output logic [DMA_W-1:0] direct_addr,
   output logic [REG_W-1:0] pte_addr,
   output logic [DMA_W-1:0] sg_addr
);
   logic [REG_W-1:0] open_bits;
   logic [REG_W-1:0] pass_mask;
   logic [REG_W-1:0] direct_full;
   logic [REG_W-1:0] tba_keep;
   logic [REG_W-1:0] idx_sel;
   logic [REG_W-1:0] sg_full;

   assign open_bits   = snap_mask & WIN_FIELD;
   assign pass_mask   = open_bits | LOW_PASS;
   assign direct_full = (snap_bus & pass_mask) | (snap_tba & ~pass_mask);
   assign direct_addr = direct_full[DMA_W-1:0];

   assign tba_keep = ~((open_bits >> PTE_SHIFT) | PTE_ALIGN);
   assign idx_sel  = open_bits | PTE_IDX_FIELD;
   assign pte_addr = (snap_tba & tba_keep) | ((snap_bus & idx_sel) >> PTE_SHIFT);

   assign sg_full  = ((entry & ~64'd1) << PAGE_SHIFT) | (snap_bus & PAGE_OFS);
   assign sg_addr  = sg_full[DMA_W-1:0];
endmodule

// File: rtl/dma_window_xlate.sv
module dma_window_xlate
   import xlate_pkg::*;
#(
   parameter int NWIN  = 4,
   parameter int BUS_W = 32,
   parameter int DMA_W = 34,
   parameter int OFS_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_valid,
   input  logic                reg_write,
   input  logic [OFS_W-1:0]    reg_addr,
   input  logic [3:0]          reg_size,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic                reg_ack,
   output logic                reg_err,
   output logic [REG_W-1:0]    reg_rdata,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [BUS_W-1:0]    req_addr,
   output logic                res_valid,
   output logic                res_hit,
   output logic [DMA_W-1:0]    res_addr,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic [REG_W-1:0]    mem_req_addr,
   input  logic                mem_rsp_valid,
   input  logic [REG_W-1:0]    mem_rsp_data
);
   localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1;

   if (NWIN < 1 || BUS_W > REG_W || DMA_W > REG_W || BUS_W <= WIN_HI) begin : g_param_check
      $error("dma_window_xlate: unsupported parameter set");
   end

   logic [NWIN-1:0][REG_W-1:0] wbase;
   logic [NWIN-1:0][REG_W-1:0] wmask;
   logic [NWIN-1:0][REG_W-1:0] tbase;

   xlate_regs #(.NWIN(NWIN), .OFS_W(OFS_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_valid (reg_valid),
      .reg_write (reg_write),
      .reg_addr  (reg_addr),
      .reg_size  (reg_size),
      .reg_wdata (reg_wdata),
      .reg_ack   (reg_ack),
      .reg_err   (reg_err),
      .reg_rdata (reg_rdata),
      .wbase     (wbase),
      .wmask     (wmask),
      .tbase     (tbase)
   );

   logic [NWIN-1:0] claim_vec;

   for (genvar i = 0; i < NWIN; i++) begin : g_win
      xlate_window #(.BUS_W(BUS_W)) u_win (
         .bus_addr (req_addr),
         .wbase    (wbase[i]),
         .wmask    (wmask[i]),
         .claim    (claim_vec[i])
      );
   end

   // lowest index wins: scan downward so the last assignment is the smallest
   logic [IW-1:0] pick;
   always_comb begin
      pick = '0;
      for (int i = NWIN - 1; i >= 0; i--)
         if (claim_vec[i]) pick = IW'(i);
   end

   xlate_state_e     state;
   logic [REG_W-1:0] snap_bus;
   logic [REG_W-1:0] snap_mask;
   logic [REG_W-1:0] snap_tba;
   logic             snap_hit;
   logic             snap_sg;
   logic [REG_W-1:0] pte_q;
   logic             hit_q;
   logic [DMA_W-1:0] addr_q;

   logic [DMA_W-1:0] direct_addr;
   logic [REG_W-1:0] pte_addr;
   logic [DMA_W-1:0] sg_addr;

   xlate_form #(.DMA_W(DMA_W)) u_form (
      .snap_bus    (snap_bus),
      .snap_mask   (snap_mask),
      .snap_tba    (snap_tba),
      .entry       (mem_rsp_data),
      .direct_addr (direct_addr),
      .pte_addr    (pte_addr),
      .sg_addr     (sg_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= XS_IDLE;
         snap_bus  <= '0;
         snap_mask <= '0;
         snap_tba  <= '0;
         snap_hit  <= 1'b0;
         snap_sg   <= 1'b0;
         pte_q     <= '0;
         hit_q     <= 1'b0;
         addr_q    <= '0;
      end else begin
         unique case (state)
            XS_IDLE: begin
               if (req_valid) begin
                  snap_bus  <= REG_W'(req_addr);
                  snap_hit  <= |claim_vec;
                  snap_sg   <= wbase[pick][1];
                  snap_mask <= wmask[pick];
                  snap_tba  <= tbase[pick];
                  state     <= XS_CMP;
               end
            end
            XS_CMP: begin
               if (!snap_hit) begin
                  hit_q  <= 1'b0;
                  addr_q <= '0;
                  state  <= XS_DONE;
               end else if (snap_sg) begin
                  pte_q <= pte_addr;
                  state <= XS_FREQ;
               end else begin
                  hit_q  <= 1'b1;
                  addr_q <= direct_addr;
                  state  <= XS_DONE;
               end
            end
            XS_FREQ: begin
               if (mem_req_ready) state <= XS_WAIT;
            end
            XS_WAIT: begin
               if (mem_rsp_valid) begin
                  hit_q  <= 1'b1;
                  addr_q <= sg_addr;
                  state  <= XS_DONE;
               end
            end
            XS_DONE: begin
               state <= XS_IDLE;
            end
            default: state <= XS_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == XS_IDLE);
   assign res_valid     = (state == XS_DONE);
   assign res_hit       = hit_q;
   assign res_addr      = addr_q;
   assign mem_req_valid = (state == XS_FREQ);
   assign mem_req_addr  = pte_q;

   assert_res_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid && req_ready);

   assert_busy_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid || res_valid) |-> !req_ready);

   assert_accept_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_hit |-> res_addr == '0);

   assert_hold_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   assert_single_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid);
endmodule

// File: tb/sim_dma_window_xlate.sv
module sim_dma_window_xlate;
   localparam int NW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0, reg_write = 1'b0;
   logic [9:0]  reg_addr = '0;
   logic [3:0]  reg_size = 4'd8;
   logic [63:0] reg_wdata = '0;
   logic        reg_ack, reg_err;
   logic [63:0] reg_rdata;
   logic        req_valid = 1'b0, req_ready;
   logic [31:0] req_addr = '0;
   logic        res_valid, res_hit;
   logic [33:0] res_addr;
   logic        mem_req_valid, mem_req_ready;
   logic [63:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [63:0] mem_rsp_data;

   always #4 clk = ~clk;

   dma_window_xlate u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
      .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
      .reg_err(reg_err), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .res_valid(res_valid), .res_hit(res_hit), .res_addr(res_addr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data)
   );

   int total = 0, bad = 0;
   bit finished = 1'b0;
   logic [63:0] m_wb [NW];
   logic [63:0] m_wm [NW];
   logic [63:0] m_tb [NW];

   int          mem_lat = 1;
   int          nfetch = 0;
   logic [63:0] last_fetch = '0;

   function automatic logic [63:0] entry_of(input logic [63:0] a);
      return {a[31:0] ^ 32'hA5C3_0F1E, a[31:0] * 32'd7 + 32'h1357_9BDF};
   endfunction

   // memory responder: accepts after a short stall, answers after mem_lat cycles
   initial begin
      bit pend = 1'b0;
      int cnt = 0, stall = 0;
      logic [63:0] paddr = '0;
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         mem_req_ready = 1'b0;
         mem_rsp_valid = 1'b0;
         if (pend) begin
            if (cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = entry_of(paddr);
               pend = 1'b0;
            end else cnt--;
         end else if (mem_req_valid) begin
            if (stall > 0) stall--;
            else begin
               mem_req_ready = 1'b1;
               paddr = mem_req_addr;
               last_fetch = mem_req_addr;
               nfetch++;
               pend = 1'b1;
               cnt = mem_lat;
               stall = mem_lat % 3;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_acc(input bit wr, input logic [9:0] ofs, input logic [3:0] sz,
                          input logic [63:0] wd, output logic [63:0] rd,
                          output logic err, output logic ack);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = wr; reg_addr = ofs; reg_size = sz; reg_wdata = wd;
      @(negedge clk);
      reg_valid = 1'b0;
      rd = reg_rdata; err = reg_err; ack = reg_ack;
   endtask

   task automatic wr_reg(input int idx, input logic [63:0] d);
      logic [63:0] rd; logic err, ack;
      reg_acc(1'b1, 10'(idx * 64), 4'd8, d, rd, err, ack);
      if (idx < NW) m_wb[idx] = d;
      else if (idx < 2 * NW) m_wm[idx - NW] = d;
      else m_tb[idx - 2 * NW] = d;
   endtask

   task automatic rd_check(input int idx, input string tag);
      logic [63:0] rd, exp; logic err, ack;
      reg_acc(1'b0, 10'(idx * 64), 4'd8, 64'd0, rd, err, ack);
      exp = (idx < NW) ? m_wb[idx] : (idx < 2 * NW) ? m_wm[idx - NW] : m_tb[idx - 2 * NW];
      chk(ack && !err && rd == exp, tag, rd, exp);
   endtask

   function automatic void model(input logic [31:0] bus, output bit hit, output bit sg,
                                 output logic [63:0] pte, output logic [33:0] addr);
      logic [63:0] a, m, p, full;
      int w;
      a = 64'(bus); hit = 1'b0; sg = 1'b0; pte = '0; addr = '0; w = -1;
      for (int i = 0; i < NW; i++)
         if (w < 0 && m_wb[i][0] &&
             (((a ^ m_wb[i]) & (~m_wm[i] & 64'h7FF0_0000)) == 0)) w = i;
      if (w < 0) return;
      hit = 1'b1;
      m = m_wm[w] & 64'h7FF0_0000;
      if (m_wb[w][1]) begin
         sg = 1'b1;
         pte = (m_tb[w] & ~((m >> 10) | 64'h3FF)) | ((a & (m | 64'hFE000)) >> 10);
         full = ((entry_of(pte) & ~64'd1) << 12) | (a & 64'h1FFF);
      end else begin
         p = m | 64'hFFFFF;
         full = (a & p) | (m_tb[w] & ~p);
      end
      addr = full[33:0];
   endfunction

   task automatic start_x(input logic [31:0] bus);
      bit acc;
      @(negedge clk);
      req_valid = 1'b1; req_addr = bus;
      forever begin
         acc = req_ready;
         @(posedge clk);
         if (acc) break;
         @(negedge clk);
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_x(input string tag, output bit hit, output logic [33:0] addr);
      int n = 0;
      bit busy_ok = 1'b1;
      hit = 1'b0; addr = '0;
      while (!res_valid && n < 60) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
         n++;
      end
      chk(res_valid, {tag, " result arrives"}, 64'(res_valid), 64'd1);
      hit = res_hit; addr = res_addr;
      chk(busy_ok, "R12 ready low while busy", 64'(busy_ok), 64'd1);
      @(negedge clk);
      chk(!res_valid && req_ready, "R12 one-cycle result pulse", 64'(res_valid), 64'd0);
   endtask

   task automatic xlate_check(input logic [31:0] bus, input string tag);
      bit ehit, esg, ahit;
      logic [63:0] epte;
      logic [33:0] eaddr, aaddr;
      int f0;
      model(bus, ehit, esg, epte, eaddr);
      f0 = nfetch;
      start_x(bus);
      wait_x(tag, ahit, aaddr);
      chk(ahit == ehit, {tag, " hit"}, 64'(ahit), 64'(ehit));
      chk(aaddr == eaddr, {tag, " addr"}, 64'(aaddr), 64'(eaddr));
      chk(nfetch - f0 == (esg ? 1 : 0), "R9 fetch count (R7 none on miss)",
          64'(nfetch - f0), 64'(esg));
      if (esg) chk(last_fetch == epte, "R9 entry address", last_fetch, epte);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] rd; logic err, ack;
      bit ahit; logic [33:0] aaddr;
      void'($urandom(32'd7741));
      for (int i = 0; i < NW; i++) begin m_wb[i] = 0; m_wm[i] = 0; m_tb[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 3 * NW; i++) rd_check(i, "R1 reset register value");
      xlate_check(32'h1234_5678, "R1 miss after reset");

      // R2 write/readback
      for (int i = 0; i < 3 * NW; i++) wr_reg(i, {32'(i) * 32'h0101_0101, 32'hDEAD_0000 | 32'(i)});
      for (int i = 0; i < 3 * NW; i++) rd_check(i, "R2 readback");

      // R3 narrow and unmapped accesses
      reg_acc(1'b1, 10'd0, 4'd4, 64'hFFFF_FFFF_FFFF_FFFF, rd, err, ack);
      chk(ack && err, "R3 narrow write err", 64'(err), 64'd1);
      rd_check(0, "R3 narrow write ignored");
      reg_acc(1'b0, 10'(5 * 64), 4'd2, 64'd0, rd, err, ack);
      chk(ack && err && rd == 0, "R3 narrow read err/zero", rd, 64'd0);
      reg_acc(1'b1, 10'(12 * 64), 4'd8, 64'h55, rd, err, ack);
      chk(ack && err, "R3 unmapped index err", 64'(err), 64'd1);
      for (int i = 0; i < 3 * NW; i++) rd_check(i, "R3 unmapped write ignored");

      // R4 R5 R6 R8 R11: overlapping windows, window 0 off, 1 and 2 direct on
      wr_reg(0, 64'h0000_0000_4000_0000);           // matches, disabled
      wr_reg(4, 64'h0000_0000_0FF0_0000);
      wr_reg(8, 64'hFFFF_FFFF_FFFF_FFFF);
      wr_reg(1, 64'h0000_0000_4000_0001);           // matches, direct
      wr_reg(5, 64'h0000_0000_0FF0_0000);
      wr_reg(9, 64'hF0F0_F0F3_A5A5_A5A5);           // high bits test truncation
      wr_reg(2, 64'h0000_0000_4000_0001);
      wr_reg(6, 64'h0000_0000_0000_0000);
      wr_reg(10, 64'h0000_0000_1111_1111);
      wr_reg(3, 64'h0000_0000_0000_0000);
      xlate_check(32'h4ABC_DEF0, "R5 R6 R8 R11 disabled skip, lowest wins");
      xlate_check(32'h7ABC_DEF0, "R4 R7 no match on bit 29");
      xlate_check(32'hC000_1234, "R4 bit 31 not compared");

      // R9 R10 R11 page-table mode on window 1
      wr_reg(1, 64'h0000_0000_4000_0003);
      wr_reg(9, 64'hFFFF_FFFF_FFFF_E000);
      mem_lat = 2;
      xlate_check(32'h4ABC_DEF0, "R9 R10 R11 page-table mode");
      mem_lat = 0;
      xlate_check(32'h4123_4567, "R10 zero-latency entry");

      // R13 write during pending fetch
      begin
         bit eh, es; logic [63:0] ep; logic [33:0] ea;
         mem_lat = 8;
         model(32'h4555_1FFF, eh, es, ep, ea);
         start_x(32'h4555_1FFF);
         wr_reg(9, 64'h0);
         wr_reg(1, 64'h0);
         wait_x("R13 snapshot", ahit, aaddr);
         chk(ahit && aaddr == ea, "R13 in-flight write no effect", 64'(aaddr), 64'(ea));
         mem_lat = 1;
      end

      // random configurations
      for (int cfg = 0; cfg < 6; cfg++) begin
         for (int w = 0; w < NW; w++) begin
            logic [63:0] b;
            b = {$urandom, $urandom};
            b[1:0] = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) != 0) b[0] = 1'b1;
            wr_reg(w, b);
            wr_reg(NW + w, {$urandom, $urandom} & ~(64'h7000_0000 >> (w * 1)));
            wr_reg(2 * NW + w, {$urandom, $urandom});
         end
         for (int t = 0; t < 40; t++) begin
            logic [31:0] bus;
            int w;
            w = $urandom_range(0, NW - 1);
            if ($urandom_range(0, 4) == 0) bus = $urandom;
            else bus = m_wb[w][31:0] ^ ($urandom & (m_wm[w][31:0] | 32'h800F_FFFF));
            mem_lat = $urandom_range(0, 4);
            xlate_check(bus, "R4 R6 R8 R10 random");
         end
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule